// File: doc/BRIEF.md
# Receive FIFO with Trigger Flags

This block buffers received bytes for a serial controller. A deserializer hands it one byte at a time, and the CPU takes bytes out through a read strobe. The FIFO holds up to sixteen bytes and reports how many it holds. It raises a receive-full flag once the occupancy reaches a trigger level that software selects. It raises a data-ready flag when a few bytes sit below that level and the line has been quiet for two frame periods. It raises an overrun flag when a byte arrives while the FIFO is full.

The flags drive a receive interrupt, an error interrupt and a one-cycle DMA request. A frame-tick input marks each frame period for the quiet-line check. A synchronous flush empties the FIFO. While the overrun flag is set, no further bytes are accepted until software writes the flag to zero.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset the occupancy is 0, every flag, both interrupts and the DMA request are 0, and rd_byte is 0x00.
- R2: Accepted bytes leave in arrival order. rd_byte shows the oldest byte combinationally. The occupancy rises by one for each accepted byte and falls by one for each pop, up to a maximum of 16.
- R3: trig_sel codes 0, 1, 2 and 3 select trigger levels of 1, 4, 8 and 14 bytes. On the edge after an accepted byte brings the occupancy to the level or above, full_flag is 1. On that same edge dma_req is 1 for exactly one cycle, and rx_irq is 1 if rx_irq_en is set.
- R4: A byte that is offered while the FIFO holds 16 is discarded and sets overrun_flag. It also sets err_irq if rx_irq_en or rx_err_irq_en is 1. overrun_flag stays set until it is cleared.
- R5: A byte is accepted only when rx_en is 1 and overrun_flag is 0. Any other byte leaves the occupancy and the contents unchanged.
- R6: The quiet-line check runs on each frame_tick. A tick counts as quiet when no byte was accepted since the previous tick or in the tick cycle itself. If both this tick and the previous tick are quiet, the FIFO is non-empty, the FIFO is below the trigger level and ready_flag is 0, then ready_flag becomes 1 and dma_req pulses. rx_irq also becomes 1 if rx_irq_en is set.
- R7: A pop with rd_may_clear set that leaves fewer bytes than the trigger level clears full_flag. If that pop leaves the FIFO empty, it also clears ready_flag. rx_irq drops when both flags end up clear. A pop without rd_may_clear leaves the flags unchanged.
- R8: fifo_flush empties the FIFO, zeroes the occupancy, clears full_flag and ready_flag and drops rx_irq. Any push or pop in the same cycle is ignored.
- R9: A pop from an empty FIFO reads 0x00 and changes no state.
- R10: ovr_wr_zero clears overrun_flag. err_irq drops with it only when other_err_pending is 0; otherwise err_irq stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rx_err_irq_en | input | 1 | Receive-error interrupt enable |
| trig_sel | input | 2 | Trigger level code (0:1, 1:4, 2:8, 3:14) |
| in_valid | input | 1 | Byte offered by the deserializer this cycle |
| in_byte | input | 8 | Offered byte |
| frame_tick | input | 1 | One-cycle pulse per frame period |
| rd_pop | input | 1 | CPU read of the data register (pop) |
| rd_may_clear | input | 1 | This pop is allowed to clear flags |
| rd_byte | output | 8 | Oldest byte, 0x00 when empty |
| fifo_flush | input | 1 | Synchronous FIFO reset |
| ovr_wr_zero | input | 1 | Software writes 0 to the overrun flag |
| other_err_pending | input | 1 | Another receive error is still pending |
| occupancy | output | 5 | Bytes held |
| full_flag | output | 1 | Receive-full flag |
| ready_flag | output | 1 | Data-ready (quiet line) flag |
| overrun_flag | output | 1 | Overrun flag |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Error interrupt |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
The assertions assume that frame_tick, rd_pop, fifo_flush and ovr_wr_zero are single-cycle strobes, sampled at the clock edge like every other input. They also assume that trig_sel is held steady enough for one evaluation to match the level in force. The stimulus changes inputs only on the falling edge and releases the strobes after each cycle. It varies trig_sel only between bursts in the directed part. In the mixed part, any input may take any value in any cycle, which stays within these assumptions because the model samples the same values the design does.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  // trigger level for a 2-bit code
  function automatic int unsigned trig_level(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  // occupancy after one cycle of accepted push / pop
  function automatic int unsigned next_occ(input int unsigned occ, input logic inc,
                                           input logic dec);
    return occ + (inc ? 1 : 0) - (dec ? 1 : 0);
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] occ_nxt,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full
);
  import rxf_pkg::*;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (occ == '0);
  assign full      = (occ == CW'(DEPTH));
  assign head_data = empty ? '0 : mem[rptr];
  assign occ_nxt   = clear ? '0 : CW'(next_occ(int'(occ), wr_en, rd_en));

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk)
      if (wr_en && wptr == AW'(i)) mem[i] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (wr_en) wptr <= bump(wptr);
      if (rd_en) rptr <= bump(rptr);
      occ <= occ_nxt;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !clear) |=> (occ == $past(occ) + 1'b1)); // R2
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty); // R8
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push_ok,
  input  logic          push_drop,
  input  logic          pop_ok,
  input  logic          pop_clr,
  input  logic          tick,
  input  logic          rie,
  input  logic          reie,
  input  logic          ovr_clr,
  input  logic          other_err,
  input  logic [CW-1:0] occ_nxt,
  input  logic [CW-1:0] lvl,
  output logic          rdf,
  output logic          dr,
  output logic          ovr,
  output logic          rx_irq,
  output logic          err_irq,
  output logic          dma
);
  logic arrived_q, prev_q;
  logic rdf_n, dr_n, irq_n, dma_n, arr_n, prev_n, ovr_n, err_n;
  logic full_evt, drain_evt, quiet_evt, rcvd;

  // named events for checking
  assign full_evt  = push_ok && (occ_nxt >= lvl);
  assign drain_evt = pop_ok && pop_clr && (occ_nxt < lvl);
  assign rcvd      = arrived_q || push_ok;

  always_comb begin
    rdf_n = rdf; dr_n = dr; irq_n = rx_irq; dma_n = 1'b0;
    arr_n = arrived_q; prev_n = prev_q; quiet_evt = 1'b0;
    if (clear) begin
      rdf_n = 1'b0; dr_n = 1'b0; irq_n = 1'b0;
      arr_n = 1'b0; prev_n = 1'b0;
    end else begin
      if (full_evt) begin
        rdf_n = 1'b1; dma_n = 1'b1;
        if (rie) irq_n = 1'b1;
      end
      if (drain_evt) begin
        rdf_n = 1'b0;
        if (occ_nxt == '0) dr_n = 1'b0;
        if (!rdf_n && !dr_n) irq_n = 1'b0;
      end
      if (tick) begin
        quiet_evt = !rcvd && !prev_q && (occ_nxt != '0) && (occ_nxt < lvl) && !dr_n;
        if (quiet_evt) begin
          dr_n = 1'b1; dma_n = 1'b1;
          if (rie) irq_n = 1'b1;
        end
        prev_n = rcvd;
        arr_n  = 1'b0;
      end else begin
        arr_n = rcvd;
      end
    end
    ovr_n = ovr; err_n = err_irq;
    if (ovr_clr) begin
      ovr_n = 1'b0;
      if (!other_err) err_n = 1'b0;
    end
    if (push_drop) begin
      ovr_n = 1'b1;
      if (rie || reie) err_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdf <= 1'b0; dr <= 1'b0; rx_irq <= 1'b0; dma <= 1'b0;
      arrived_q <= 1'b0; prev_q <= 1'b0; ovr <= 1'b0; err_irq <= 1'b0;
    end else begin
      rdf <= rdf_n; dr <= dr_n; rx_irq <= irq_n; dma <= dma_n;
      arrived_q <= arr_n; prev_q <= prev_n; ovr <= ovr_n; err_irq <= err_n;
    end
  end

  AST_FULL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (full_evt && !clear) |=> (rdf && dma)); // R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !ovr_clr) |=> ovr); // R4
  AST_ERR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_irq && ovr_clr && other_err) |=> err_irq); // R10
  AST_DR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dr) |-> $past(tick)); // R6
  AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_evt && !clear) |=> !rdf); // R7
endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          rx_irq_en,
  input  logic          rx_err_irq_en,
  input  logic [1:0]    trig_sel,
  input  logic          in_valid,
  input  logic [DW-1:0] in_byte,
  input  logic          frame_tick,
  input  logic          rd_pop,
  input  logic          rd_may_clear,
  output logic [DW-1:0] rd_byte,
  input  logic          fifo_flush,
  input  logic          ovr_wr_zero,
  input  logic          other_err_pending,
  output logic [CW-1:0] occupancy,
  output logic          full_flag,
  output logic          ready_flag,
  output logic          overrun_flag,
  output logic          rx_irq,
  output logic          err_irq,
  output logic          dma_req
);
  import rxf_pkg::*;

  logic          push_try, push_ok, push_drop, pop_ok;
  logic          empty, full;
  logic [CW-1:0] occ_nxt, lvl;

  assign lvl       = CW'(trig_level(trig_sel));
  assign push_try  = in_valid && rx_en && !overrun_flag && !fifo_flush;
  assign push_ok   = push_try && !full;
  assign push_drop = push_try && full;
  assign pop_ok    = rd_pop && !empty && !fifo_flush;

  rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(fifo_flush),
    .wr_en(push_ok), .wr_data(in_byte), .rd_en(pop_ok),
    .occ(occupancy), .occ_nxt(occ_nxt), .head_data(rd_byte),
    .empty(empty), .full(full)
  );

  rxf_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst_n(rst_n), .clear(fifo_flush),
    .push_ok(push_ok), .push_drop(push_drop), .pop_ok(pop_ok),
    .pop_clr(rd_may_clear), .tick(frame_tick),
    .rie(rx_irq_en), .reie(rx_err_irq_en),
    .ovr_clr(ovr_wr_zero), .other_err(other_err_pending),
    .occ_nxt(occ_nxt), .lvl(lvl),
    .rdf(full_flag), .dr(ready_flag), .ovr(overrun_flag),
    .rx_irq(rx_irq), .err_irq(err_irq), .dma(dma_req)
  );

  AST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_flag && in_valid && !rd_pop && !fifo_flush) |=> $stable(occupancy)); // R5
  AST_FLUSH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> (!rx_irq && !full_flag && !ready_flag)); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && occupancy == '0 && !in_valid) |=> (occupancy == '0)); // R9
  AST_DROP_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> overrun_flag); // R4
endmodule

// File: tb/rx_trig_fifo_test.sv
`timescale 1ns/100ps
module rx_trig_fifo_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, rie = 1'b0, reie = 1'b0;
  logic [1:0] tsel = 2'd0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic tick = 1'b0, pop = 1'b0, pclr = 1'b0, flush = 1'b0, oclr = 1'b0, oth = 1'b0;
  logic [7:0] rd_byte;
  logic [4:0] occ;
  logic full_flag, ready_flag, ovr_flag, rx_irq, err_irq, dma_req;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  rx_trig_fifo uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_irq_en(rie), .rx_err_irq_en(reie),
    .trig_sel(tsel), .in_valid(in_valid), .in_byte(in_byte), .frame_tick(tick),
    .rd_pop(pop), .rd_may_clear(pclr), .rd_byte(rd_byte), .fifo_flush(flush),
    .ovr_wr_zero(oclr), .other_err_pending(oth), .occupancy(occ),
    .full_flag(full_flag), .ready_flag(ready_flag), .overrun_flag(ovr_flag),
    .rx_irq(rx_irq), .err_irq(err_irq), .dma_req(dma_req)
  );

  // reference model state
  byte unsigned q[$];
  bit m_rdf, m_dr, m_ovr, m_irq, m_err, m_dma, m_arr, m_prev;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lvl_of(input logic [1:0] c);
    if (c == 2'd0) return 1;
    if (c == 2'd1) return 4;
    if (c == 2'd2) return 8;
    return 14;
  endfunction

  task automatic model_update();
    int lvl, nc;
    bit attempt, ok, drop, popok, rcvd;
    lvl = lvl_of(tsel);
    m_dma = 0;
    attempt = in_valid && rx_en && !m_ovr && !flush;
    ok = attempt && (q.size() < 16);
    drop = attempt && (q.size() == 16);
    if (flush) begin
      q.delete();
      m_rdf = 0; m_dr = 0; m_irq = 0; m_arr = 0; m_prev = 0;
    end else begin
      popok = pop && (q.size() > 0);
      if (popok) void'(q.pop_front());
      if (ok) q.push_back(in_byte);
      nc = q.size();
      if (ok && nc >= lvl) begin
        m_rdf = 1; m_dma = 1;
        if (rie) m_irq = 1;
      end
      if (popok && pclr && nc < lvl) begin
        m_rdf = 0;
        if (nc == 0) m_dr = 0;
        if (!m_rdf && !m_dr) m_irq = 0;
      end
      rcvd = m_arr || ok;
      if (tick) begin
        if (!rcvd && !m_prev && nc != 0 && nc < lvl && !m_dr) begin
          m_dr = 1; m_dma = 1;
          if (rie) m_irq = 1;
        end
        m_prev = rcvd;
        m_arr = 0;
      end else m_arr = rcvd;
    end
    if (oclr) begin
      m_ovr = 0;
      if (!oth) m_err = 0;
    end
    if (drop) begin
      m_ovr = 1;
      if (rie || reie) m_err = 1;
    end
  endtask

  // one clock: inputs already set at the falling edge
  task automatic step();
    int exp_b;
    #1;
    exp_b = (q.size() > 0) ? int'(q[0]) : 0;
    chk(rd_byte == 8'(exp_b), "R2 rd_byte order", rd_byte, exp_b);
    model_update();
    @(posedge clk);
    @(negedge clk);
    chk(occ == 5'(q.size()), "R2 occupancy", occ, q.size());
    chk(full_flag == m_rdf, "R3 full_flag", full_flag, m_rdf);
    chk(dma_req == m_dma, "R3 dma_req", dma_req, m_dma);
    chk(ready_flag == m_dr, "R6 ready_flag", ready_flag, m_dr);
    chk(ovr_flag == m_ovr, "R4 overrun_flag", ovr_flag, m_ovr);
    chk(rx_irq == m_irq, "R7 rx_irq", rx_irq, m_irq);
    chk(err_irq == m_err, "R10 err_irq", err_irq, m_err);
    in_valid = 0; tick = 0; pop = 0; flush = 0; oclr = 0;
  endtask

  task automatic push(input byte unsigned b);
    in_valid = 1; in_byte = b; step();
  endtask

  task automatic popc(input bit clr);
    pop = 1; pclr = clr; step();
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(occ == 0 && !full_flag && !ready_flag && !ovr_flag, "R1 flags", occ, 0);
    chk(!rx_irq && !err_irq && !dma_req && rd_byte == 0, "R1 outputs", rd_byte, 0);
    @(negedge clk);

    // R3 level 1 with interrupts
    rx_en = 1; rie = 1; tsel = 2'd0;
    push(8'hA5);
    chk(full_flag && rx_irq && dma_req, "R3 level1 set", full_flag, 1);
    step();
    chk(!dma_req, "R3 dma one cycle", dma_req, 0);
    popc(1);
    chk(!full_flag && !rx_irq, "R7 drained", rx_irq, 0);

    // R7 pop without clear keeps flags
    push(8'h11);
    popc(0);
    chk(full_flag && rx_irq, "R7 no-clear keeps", full_flag, 1);
    flush = 1; step();
    chk(!full_flag && !rx_irq && occ == 0, "R8 flush", occ, 0);

    // R6 quiet-line timeout at level 8
    tsel = 2'd2;
    for (int i = 0; i < 5; i++) push(8'(8'h20 + i));
    tick = 1; step(); step();
    tick = 1; step(); step();
    chk(!ready_flag, "R6 not yet", ready_flag, 0);
    tick = 1; step();
    chk(ready_flag && rx_irq && dma_req, "R6 set", ready_flag, 1);
    for (int i = 0; i < 5; i++) popc(1);
    chk(!ready_flag && !rx_irq, "R7 empty clears ready", ready_flag, 0);

    // R9 pop from empty
    popc(1);
    chk(occ == 0 && rd_byte == 0, "R9 empty pop", occ, 0);

    // R4 overrun, error enable only
    rie = 0; reie = 1; tsel = 2'd3;
    for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
    chk(occ == 16 && full_flag, "R3 level14 full", occ, 16);
    push(8'hEE);
    chk(ovr_flag && err_irq && occ == 16, "R4 overrun", ovr_flag, 1);
    popc(0);
    push(8'hEF);
    chk(occ == 15, "R5 blocked by overrun", occ, 15);
    oth = 1; oclr = 1; step();
    chk(!ovr_flag && err_irq, "R10 err held", err_irq, 1);
    oth = 0; oclr = 1; step();
    chk(!err_irq, "R10 err dropped", err_irq, 0);
    rx_en = 0; push(8'h77);
    chk(occ == 15, "R5 rx disabled", occ, 15);
    rx_en = 1;
    for (int i = 0; i < 15; i++) popc(1);
    chk(occ == 0 && !full_flag, "R2 drained in order", occ, 0);

    // level 4
    tsel = 2'd1; rie = 1;
    for (int i = 0; i < 3; i++) push(8'(i + 1));
    chk(!full_flag, "R3 below level4", full_flag, 0);
    push(8'h04);
    chk(full_flag, "R3 at level4", full_flag, 1);

    // mixed stimulus
    for (int n = 0; n < 3000; n++) begin
      rx_en = ($urandom_range(0, 9) != 0);
      rie = $urandom_range(0, 1); reie = $urandom_range(0, 1);
      if ($urandom_range(0, 40) == 0) tsel = 2'($urandom_range(0, 3));
      in_valid = ($urandom_range(0, 2) == 0);
      in_byte = 8'($urandom_range(0, 255));
      tick = ($urandom_range(0, 5) == 0);
      pop = ($urandom_range(0, 3) == 0);
      pclr = $urandom_range(0, 1);
      flush = ($urandom_range(0, 150) == 0);
      oclr = ($urandom_range(0, 30) == 0);
      oth = $urandom_range(0, 1);
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule